// File: doc/BRIEF.md
# Single-Precision Operand Classify and Flush Stage

This block is the edge logic of a single-precision floating-point unit that runs in flush-to-zero mode. On the intake side it accepts a pair of 32-bit operands over a valid/ready handshake. For each operand it registers a class vector and a copy whose subnormal mantissa has been cleared, ready for the arithmetic core. The class vector is always derived from the operand as it arrived, so a classify instruction reading it still sees subnormals as subnormals even though the core only ever sees signed zeros.

On the result side a purely combinational path takes the core's raw result word together with its underflow and zero indications. It produces the final word, clearing exponent and mantissa whenever the result underflowed, is zero, or would be subnormal. The sign is kept. The intake register is a single slice. A new pair is accepted when the slice is empty or when its contents are being taken in the same cycle. While the downstream side holds `out_ready` low, the registered outputs stay frozen and `in_ready` stays low.

Top module: `fp_sp_intake_flush`

## Requirements
- R1: Each class vector is exactly one-hot over 10 bits, with bit 0 = negative infinity, 1 = negative normal, 2 = negative subnormal, 3 = negative zero, 4 = positive zero, 5 = positive subnormal, 6 = positive normal, 7 = positive infinity, 8 = signalling NaN, 9 = quiet NaN.
- R2: An operand with exponent bits 30..23 all zero and a non-zero mantissa (bits 22..0) is classed as subnormal of its sign (bit 31), never as zero.
- R3: The flushed operand equals the input with bits 22..0 cleared when bits 30..23 are all zero. Bit 31 is kept, so a negative subnormal becomes 0x80000000. Any other operand passes unchanged.
- R4: An exponent of all ones with a zero mantissa is an infinity of its sign. With a non-zero mantissa it is a NaN of either sign: quiet when bit 22 is 1 and signalling when bit 22 is 0.
- R5: A pair is taken on a rising edge where `in_valid` and `in_ready` are both high, and `out_valid` is high in the following cycle. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and all registered outputs hold their values across the clock edge.
- R7: After reset, `out_valid` is low.
- R8: `res_final` has bits 30..0 forced to zero when `res_underflow` is 1, when `res_zero` is 1, or when `res_raw` has an all-zero exponent and a non-zero mantissa. Otherwise it equals `res_raw`. Bit 31 always equals `res_raw` bit 31.
- R9: The result path is combinational and works in the same cycle as an intake transfer, unaffected by the intake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Stage can take a pair |
| in_opa | input | 32 | First operand, raw bits |
| in_opb | input | 32 | Second operand, raw bits |
| out_valid | output | 1 | Registered pair available |
| out_ready | input | 1 | Downstream takes the pair |
| out_opa | output | 32 | First operand after input flush |
| out_opb | output | 32 | Second operand after input flush |
| out_cls_a | output | 10 | Class of first raw operand |
| out_cls_b | output | 10 | Class of second raw operand |
| res_raw | input | 32 | Raw result from the core |
| res_underflow | input | 1 | Core reports underflow |
| res_zero | input | 1 | Core reports a zero result |
| res_final | output | 32 | Result after output flush |

## Verification
The intake handshake and the result flush can both act in the same cycle, because they share no state. The bench offers a pair of subnormal operands on the same edge where it presents an underflowing negative result. It then checks the result word before the edge, and the registered flushed pair and class vectors after it, each against values fixed by the requirements. A stalled slice combined with a result flush is also exercised, to show that back-pressure on the intake leaves the result path unaffected.

// File: rtl/fp_cls_pkg.sv
package fp_cls_pkg;
  localparam int CLS_W = 10;
  localparam int C_NINF  = 0;
  localparam int C_NNORM = 1;
  localparam int C_NSUB  = 2;
  localparam int C_NZERO = 3;
  localparam int C_PZERO = 4;
  localparam int C_PSUB  = 5;
  localparam int C_PNORM = 6;
  localparam int C_PINF  = 7;
  localparam int C_SNAN  = 8;
  localparam int C_QNAN  = 9;
  typedef logic [CLS_W-1:0] cls_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fp_cls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output cls_t                 cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             e_zero, e_ones, m_zero;

  assign sgn    = word[W-1];
  assign ex     = word[W-2 -: EXP_W];
  assign mn     = word[MAN_W-1:0];
  assign e_zero = (ex == '0);
  assign e_ones = (ex == '1);
  assign m_zero = (mn == '0);

  always_comb begin
    cls = '0;
    if (e_ones && !m_zero) begin
      if (mn[MAN_W-1]) cls[C_QNAN] = 1'b1;
      else             cls[C_SNAN] = 1'b1;
    end else if (e_ones) begin
      if (sgn) cls[C_NINF] = 1'b1;
      else     cls[C_PINF] = 1'b1;
    end else if (e_zero && m_zero) begin
      if (sgn) cls[C_NZERO] = 1'b1;
      else     cls[C_PZERO] = 1'b1;
    end else if (e_zero) begin
      if (sgn) cls[C_NSUB] = 1'b1;
      else     cls[C_PSUB] = 1'b1;
    end else begin
      if (sgn) cls[C_NNORM] = 1'b1;
      else     cls[C_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_in_flush.sv
module fp_in_flush #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] raw,
  output logic [EXP_W+MAN_W:0] flushed
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic e_zero;
  assign e_zero = (raw[W-2 -: EXP_W] == '0);

  always_comb begin
    flushed = raw;
    if (e_zero) flushed[MAN_W-1:0] = '0;
  end
endmodule

// File: rtl/fp_out_flush.sv
module fp_out_flush
  import fp_cls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] raw,
  input  logic                 uf,
  input  logic                 zero,
  output logic [EXP_W+MAN_W:0] result
);
  localparam int W = 1 + EXP_W + MAN_W;

  cls_t rcls;
  logic kill;

  fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (.word(raw), .cls(rcls));

  assign kill = uf || zero || rcls[C_NSUB] || rcls[C_PSUB];

  always_comb begin
    result = raw;
    if (kill) result[W-2:0] = '0;
  end
endmodule

// File: rtl/fp_sp_intake_flush.sv
module fp_sp_intake_flush
  import fp_cls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EXP_W+MAN_W:0] in_opa,
  input  logic [EXP_W+MAN_W:0] in_opb,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [EXP_W+MAN_W:0] out_opa,
  output logic [EXP_W+MAN_W:0] out_opb,
  output logic [CLS_W-1:0]     out_cls_a,
  output logic [CLS_W-1:0]     out_cls_b,
  input  logic [EXP_W+MAN_W:0] res_raw,
  input  logic                 res_underflow,
  input  logic                 res_zero,
  output logic [EXP_W+MAN_W:0] res_final
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int NUM_OP = 2;

  logic [W-1:0] op_raw  [NUM_OP];
  logic [W-1:0] op_fl   [NUM_OP];
  cls_t         op_cls  [NUM_OP];
  logic [W-1:0] q_fl    [NUM_OP];
  cls_t         q_cls   [NUM_OP];
  logic         take;
  logic         vld_q;

  assign op_raw[0] = in_opa;
  assign op_raw[1] = in_opb;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar g = 0; g < NUM_OP; g++) begin : g_op
    fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
      .word(op_raw[g]), .cls(op_cls[g]));
    fp_in_flush #(.EXP_W(EXP_W), .MAN_W(MAN_W)) fl_i (
      .raw(op_raw[g]), .flushed(op_fl[g]));

    always_ff @(posedge clk) begin
      if (take) begin
        q_fl[g]  <= op_fl[g];
        q_cls[g] <= op_cls[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         vld_q <= 1'b0;
    else if (take)      vld_q <= 1'b1;
    else if (out_ready) vld_q <= 1'b0;
  end

  assign out_valid = vld_q;
  assign out_opa   = q_fl[0];
  assign out_opb   = q_fl[1];
  assign out_cls_a = q_cls[0];
  assign out_cls_b = q_cls[1];

  fp_out_flush #(.EXP_W(EXP_W), .MAN_W(MAN_W)) ofl_i (
    .raw(res_raw), .uf(res_underflow), .zero(res_zero), .result(res_final));
endmodule

// File: rtl/fp_sp_intake_flush_chk.sv
module fp_sp_intake_flush_chk
  import fp_cls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [EXP_W+MAN_W:0] in_opa,
  input logic [EXP_W+MAN_W:0] in_opb,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EXP_W+MAN_W:0] out_opa,
  input logic [EXP_W+MAN_W:0] out_opb,
  input logic [CLS_W-1:0]     out_cls_a,
  input logic [CLS_W-1:0]     out_cls_b,
  input logic [EXP_W+MAN_W:0] res_raw,
  input logic                 res_underflow,
  input logic                 res_zero,
  input logic [EXP_W+MAN_W:0] res_final
);
  localparam int W = 1 + EXP_W + MAN_W;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_cls_a) == 1 && $countones(out_cls_b) == 1));

  a_r3_sub_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_cls_a[C_NSUB] || out_cls_a[C_PSUB]))
      |-> (out_opa[W-2:0] == '0 && out_opa[W-1] == out_cls_a[C_NSUB]));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opa) &&
      $stable(out_opb) && $stable(out_cls_a) && $stable(out_cls_b)));

  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_uf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_underflow || res_zero) |-> (res_final[W-2:0] == '0));

  a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
    res_final[W-1] == res_raw[W-1]);
endmodule

bind fp_sp_intake_flush fp_sp_intake_flush_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (.*);

// File: tb/fp_sp_intake_flush_tb_top.sv
module fp_sp_intake_flush_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_opa = '0, in_opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_opa, out_opb;
  logic [9:0]  out_cls_a, out_cls_b;
  logic [31:0] res_raw = '0;
  logic        res_underflow = 1'b0, res_zero = 1'b0;
  logic [31:0] res_final;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fp_sp_intake_flush dut_i (.*);

  localparam int NV = 13;
  localparam logic [31:0] V_IN [NV] = '{
    32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF, 32'h3F800000,
    32'hC0000000, 32'h00800000, 32'h7F800000, 32'hFF800000, 32'h7F800001,
    32'h7FC00000, 32'hFFC00001, 32'h7FBFFFFF};
  localparam int V_CLS [NV] = '{4, 3, 5, 2, 6, 1, 6, 7, 0, 8, 9, 9, 8};
  localparam logic [31:0] V_FL [NV] = '{
    32'h00000000, 32'h80000000, 32'h00000000, 32'h80000000, 32'h3F800000,
    32'hC0000000, 32'h00800000, 32'h7F800000, 32'hFF800000, 32'h7F800001,
    32'h7FC00000, 32'hFFC00001, 32'h7FBFFFFF};

  localparam int NR = 8;
  localparam logic [31:0] R_IN [NR] = '{
    32'h3F800000, 32'h00000005, 32'h80000005, 32'h3F800000,
    32'hBF800000, 32'hC0400000, 32'h7F800000, 32'h00000000};
  localparam logic R_UF [NR] = '{0, 0, 0, 1, 1, 0, 0, 0};
  localparam logic R_ZR [NR] = '{0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [31:0] R_EXP [NR] = '{
    32'h3F800000, 32'h00000000, 32'h80000000, 32'h00000000,
    32'h80000000, 32'h80000000, 32'h7F800000, 32'h00000000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] oh(input int idx);
    return 32'(1) << idx;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_opa = a; in_opb = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset out_valid", 32'(out_valid), 32'd1 - 32'd1);
    check("R5 ready after reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // Intake table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      int j = NV - 1 - i;
      send(V_IN[i], V_IN[j]);
      check("R5 out_valid", 32'(out_valid), 32'd1);
      check("R1 R2 R4 class a", 32'(out_cls_a), oh(V_CLS[i]));
      check("R1 R2 R4 class b", 32'(out_cls_b), oh(V_CLS[j]));
      check("R3 flush a", out_opa, V_FL[i]);
      check("R3 flush b", out_opb, V_FL[j]);
    end
    @(negedge clk);
    check("R5 drains", 32'(out_valid), 32'd0);

    // Result table: R8
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      res_raw = R_IN[i]; res_underflow = R_UF[i]; res_zero = R_ZR[i];
      #1;
      check("R8 result flush", res_final, R_EXP[i]);
    end

    // Back-pressure: R5 R6
    out_ready = 1'b0;
    send(32'h00000003, 32'h40000000);
    check("R5 stalled ready low", 32'(in_ready), 32'd0);
    in_opa = 32'h3F800000; in_opb = 32'h3F800000; in_valid = 1'b1;
    res_raw = 32'h807FFFFF; res_underflow = 1'b0; res_zero = 1'b0;
    #1;
    check("R9 flush during stall", res_final, 32'h80000000);
    @(posedge clk);
    @(negedge clk);
    check("R6 hold valid", 32'(out_valid), 32'd1);
    check("R6 hold a", out_opa, 32'h00000000);
    check("R6 hold cls a", 32'(out_cls_a), oh(5));
    check("R6 hold b", out_opb, 32'h40000000);
    out_ready = 1'b1;
    #1;
    check("R5 ready with out_ready", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 next pair taken", out_opa, 32'h3F800000);
    check("R5 next cls", 32'(out_cls_a), oh(6));

    // Same cycle: intake of subnormals and underflowing result (R9)
    @(negedge clk);
    in_opa = 32'h80000010; in_opb = 32'h00400000; in_valid = 1'b1;
    res_raw = 32'hBE000000; res_underflow = 1'b1;
    #1;
    check("R9 same-cycle result", res_final, 32'h80000000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; res_underflow = 1'b0;
    check("R9 same-cycle a", out_opa, 32'h80000000);
    check("R9 same-cycle cls a", 32'(out_cls_a), oh(2));
    check("R9 same-cycle b", out_opb, 32'h00000000);
    check("R2 same-cycle cls b", 32'(out_cls_b), oh(5));

    // Reset while valid: R7
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R7 reset clears valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule